// File: doc/BRIEF.md
# IO Address Translation Table Walker

This block turns a device-side (IO virtual) address into a physical address. It uses a single-level translation table held in system memory. A requester presents one address together with a read/write flag. The walker then answers with either a physical address and a permission code, or a fault. While translation is off, addresses go through unchanged. While it is on, the walker computes the position of one 64-bit entry inside the table, fetches that entry over a request/acknowledge read port, and decodes it.

The table geometry comes from a control word supplied by the surrounding register logic, plus a table base address. Two things set the geometry:
- The table page mode: 8 KiB or 64 KiB.
- A 3-bit size code that sets how many virtual-address bits index the table.

Each entry also names its own page size, 8 KiB or 64 KiB. A table in either mode may therefore mix both page sizes. Only one translation is handled at a time. Caching, invalidation and fault recording belong to the neighbouring blocks.

Top module: `iova_table_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_rd_req`, `rsp_fault`, `rsp_page_64k` and `rsp_perm` are all 0.
- R2: Acceptance and the done pulse:
  - A request is accepted only in a cycle where both `req_valid` and `req_ready` are 1.
  - `req_ready` stays 0 from acceptance until the cycle after `done`.
  - Each accepted request produces exactly one single-cycle `done` pulse.
  - A `req_valid` held high while busy is not taken as a second request.
- R3: Pass-through when control bit 0 is clear:
  - `done` rises in the second cycle after the accepting edge.
  - `rsp_paddr` equals the request address.
  - `rsp_perm` is 2'b11 (read-write), `rsp_fault` is 0 and `rsp_page_64k` is 0, even for writes.
  - No memory read is issued.
- R4: 8 KiB table mode (control bit 2 clear, size code n = control bits [18:16], range 0..7). The walker reads the entry at `tbl_base` + 8 × (address bits [22+n:13]).
- R5: 64 KiB table mode (control bit 2 set, n in 0..5). The walker reads the entry at `tbl_base` + 8 × (address bits [25+n:16]).
- R6: In 64 KiB table mode, size codes 6 and 7 make the walker answer with no memory read. The answer is `rsp_fault` = 1 and `rsp_perm` = 2'b00, with the same latency as R3.
- R7: An entry whose bit 63 is clear is invalid. The answer is `rsp_fault` = 1 and `rsp_perm` = 2'b00.
- R8: In a valid entry, bit 1 sets the permission: when set, `rsp_perm` is 2'b11 (read-write); when clear, it is 2'b01 (read-only).
- R9: Physical address composition for a valid entry:
  - Entry bit 61 set means a 64 KiB page. `rsp_paddr` = (entry AND 0x1FFFFFF8000) OR (address AND 0xFFFF), and `rsp_page_64k` = 1.
  - Entry bit 61 clear means an 8 KiB page. `rsp_paddr` = (entry AND 0x1FFFFFFE000) OR (address AND 0x1FFF).
- R10: A write request that meets a read-only entry gives `rsp_fault` = 1 with `rsp_perm` still 2'b01. On any fault, `rsp_paddr` and `rsp_page_64k` are 0.
- R11: The memory read handshake:
  - `mem_rd_req` and `mem_rd_addr` hold steady until `mem_rd_ack` is sampled high.
  - `done` follows in the next cycle, carrying the decoded result.
- R12: The control word and table base are captured at acceptance. Changing them during a walk does not affect that walk's answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control: bit 0 enable, bit 2 table page mode, bits [18:16] size code |
| tbl_base | input | 64 | Byte address of the translation table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 64 | IO virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_rd_req | output | 1 | Entry read request, held until acknowledged |
| mem_rd_addr | output | 64 | Byte address of the entry being read |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 64 | Entry value, bit 63 most significant |
| done | output | 1 | One-cycle pulse, result outputs valid |
| rsp_fault | output | 1 | Translation or permission fault |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_page_64k | output | 1 | Translated page is 64 KiB |
| rsp_paddr | output | 64 | Translated physical address |

## Verification
A wrong sequencer state shows up at the ports within one or two cycles. It appears as one of:
- a `req_ready` that rises early;
- a missing, doubled or late `done`;
- a read request where none is due.

The reference model predicts all three on every clock, so such an error is caught in the first cycle it diverges. A wrong index width or mode decode gives a wrong `mem_rd_addr` in the first fetch cycle. A wrong entry decode is visible only at the `done` pulse, in `rsp_paddr`, `rsp_perm` or `rsp_fault`. A corrupted captured configuration shows up only when the bench changes the live control word during a walk.

// File: rtl/iowalk_pkg.sv
`timescale 1ns/1ps
// Shared types for the IO translation table walker.
// Assumes: permission codes are fixed by the consumers of the response.
package iowalk_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_FETCH  = 2'd2,
        ST_RESP   = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic  fault;
        perm_e perm;
        logic  page_64k;
    } rsp_attr_t;

endpackage

// File: rtl/iowalk_index.sv
`timescale 1ns/1ps
// Computes the byte offset of a table entry from the virtual address.
// The offset is the index window (MIN_IDX_W + size code bits above the
// table page boundary) scaled by the entry size. Also flags size codes
// that are illegal in the large-page table mode.
// Assumes: MIN_IDX_W + 2**CODE_W - 1 < ADDR_W.
module iowalk_index #(
    parameter int ADDR_W        = 64,
    parameter int CODE_W        = 3,
    parameter int MIN_IDX_W     = 10,
    parameter int SMALL_PG_LOG2 = 13,
    parameter int BIG_PG_LOG2   = 16,
    parameter int BIG_CODES     = 6,
    parameter int ENTRY_LOG2    = 3
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              big_mode,
    input  logic [CODE_W-1:0] size_code,
    output logic [ADDR_W-1:0] byte_off,
    output logic              code_ok
);
    localparam int NCODES = 1 << CODE_W;
    localparam logic [CODE_W:0] BIG_LIMIT = (CODE_W+1)'(BIG_CODES);

    logic [ADDR_W-1:0] win_mask [NCODES];
    logic [ADDR_W-1:0] vpn;

    genvar g;
    generate
        for (g = 0; g < NCODES; g++) begin : g_win
            // One index mask per size code, each one bit wider than the last.
            assign win_mask[g] = {ADDR_W{1'b1}} >> (ADDR_W - MIN_IDX_W - g);
        end
    endgenerate

    // Select page number, apply the window and scale to entry bytes.
    always_comb begin
        vpn      = big_mode ? (va >> BIG_PG_LOG2) : (va >> SMALL_PG_LOG2);
        byte_off = (vpn & win_mask[size_code]) << ENTRY_LOG2;
        code_ok  = !big_mode || ({1'b0, size_code} < BIG_LIMIT);
    end

endmodule

// File: rtl/iowalk_entry_decode.sv
`timescale 1ns/1ps
// Decodes a fetched 64-bit table entry into a physical address and
// response attributes: valid bit, write permission, per-entry page size.
// A write against a read-only entry is a fault. Faults zero the address.
// Assumes: ENTRY_W equals ADDR_W.
module iowalk_entry_decode
    import iowalk_pkg::*;
#(
    parameter int ADDR_W        = 64,
    parameter int ENTRY_W       = 64,
    parameter int PA_HI         = 40,
    parameter int SMALL_PG_LOG2 = 13,
    parameter int BIG_PG_LOG2   = 16,
    parameter int BIG_BASE_LSB  = 15,
    parameter int VALID_BIT     = 63,
    parameter int BIG_BIT       = 61,
    parameter int RW_BIT        = 1
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [ADDR_W-1:0]  va,
    input  logic               is_write,
    output rsp_attr_t          attr,
    output logic [ADDR_W-1:0]  paddr
);
    localparam logic [ADDR_W-1:0] ONES       = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] PA_KEEP    = ONES >> (ADDR_W - 1 - PA_HI);
    localparam logic [ADDR_W-1:0] SMALL_OFF  = ONES >> (ADDR_W - SMALL_PG_LOG2);
    localparam logic [ADDR_W-1:0] BIG_OFF    = ONES >> (ADDR_W - BIG_PG_LOG2);
    localparam logic [ADDR_W-1:0] SMALL_BASE = PA_KEEP & ~SMALL_OFF;
    localparam logic [ADDR_W-1:0] BIG_BASE   = PA_KEEP & ~(ONES >> (ADDR_W - BIG_BASE_LSB));

    logic              ent_valid;
    logic              ent_rw;
    logic              ent_big;
    logic              flt;
    logic [ADDR_W-1:0] ent_a;

    // Field extraction, permission and fault decision.
    always_comb begin
        ent_a     = ADDR_W'(entry);
        ent_valid = entry[VALID_BIT];
        ent_rw    = entry[RW_BIT];
        ent_big   = entry[BIG_BIT];
        flt       = !ent_valid || (is_write && !ent_rw);
        attr.fault    = flt;
        attr.perm     = !ent_valid ? PERM_NONE : (ent_rw ? PERM_RW : PERM_RO);
        attr.page_64k = !flt && ent_big;
    end

    // Physical address: masked page base merged with the in-page offset.
    always_comb begin
        if (flt) begin
            paddr = '0;
        end else if (ent_big) begin
            paddr = (ent_a & BIG_BASE) | (va & BIG_OFF);
        end else begin
            paddr = (ent_a & SMALL_BASE) | (va & SMALL_OFF);
        end
    end

endmodule

// File: rtl/iowalk_seq.sv
`timescale 1ns/1ps
// Walk sequencer: idle, decide, fetch, respond. Issues one strobe per
// result source (pass-through, reserved code, fetched entry) and holds
// the memory read request until acknowledged.
// Assumes: mem_rd_ack is only meaningful while mem_rd_req is high.
module iowalk_seq
    import iowalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic xlate_en,
    input  logic code_ok,
    input  logic mem_rd_ack,
    output logic req_ready,
    output logic accept,
    output logic fetch_go,
    output logic mem_rd_req,
    output logic load_pass,
    output logic load_rsvd,
    output logic load_entry,
    output logic done
);
    walk_st_e state_q;
    walk_st_e state_d;

    // Next state and per-state strobes.
    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        fetch_go   = 1'b0;
        load_pass  = 1'b0;
        load_rsvd  = 1'b0;
        load_entry = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (!xlate_en) begin
                    load_pass = 1'b1;
                    state_d   = ST_RESP;
                end else if (!code_ok) begin
                    load_rsvd = 1'b1;
                    state_d   = ST_RESP;
                end else begin
                    fetch_go = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_rd_ack) begin
                    load_entry = 1'b1;
                    state_d    = ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign mem_rd_req = (state_q == ST_FETCH);
    assign done       = (state_q == ST_RESP);

endmodule

// File: rtl/iova_table_walker.sv
`timescale 1ns/1ps
// IO virtual to physical address translation through a single-level table.
// Captures the request and configuration on acceptance, computes the entry
// address, fetches one entry and registers the decoded response, which is
// marked by a single-cycle done pulse.
// Assumes: one translation at a time; memory returns the entry as a 64-bit
// value with bit 63 most significant.
module iova_table_walker
    import iowalk_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CTRL_W   = 32,
    parameter int CODE_W   = 3,
    parameter int EN_BIT   = 0,
    parameter int MODE_BIT = 2,
    parameter int CODE_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              done,
    output logic              rsp_fault,
    output logic [1:0]        rsp_perm,
    output logic              rsp_page_64k,
    output logic [ADDR_W-1:0] rsp_paddr
);
    logic [ADDR_W-1:0] cap_va;
    logic              cap_wr;
    logic              cap_en;
    logic              cap_big;
    logic [CODE_W-1:0] cap_code;
    logic [ADDR_W-1:0] cap_base;
    logic [ADDR_W-1:0] mem_addr_q;

    logic              accept;
    logic              fetch_go;
    logic              load_pass;
    logic              load_rsvd;
    logic              load_entry;
    logic              code_ok;
    logic [ADDR_W-1:0] byte_off;
    rsp_attr_t         ent_attr;
    logic [ADDR_W-1:0] ent_paddr;

    iowalk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .xlate_en   (cap_en),
        .code_ok    (code_ok),
        .mem_rd_ack (mem_rd_ack),
        .req_ready  (req_ready),
        .accept     (accept),
        .fetch_go   (fetch_go),
        .mem_rd_req (mem_rd_req),
        .load_pass  (load_pass),
        .load_rsvd  (load_rsvd),
        .load_entry (load_entry),
        .done       (done)
    );

    iowalk_index #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_index (
        .va        (cap_va),
        .big_mode  (cap_big),
        .size_code (cap_code),
        .byte_off  (byte_off),
        .code_ok   (code_ok)
    );

    iowalk_entry_decode #(
        .ADDR_W  (ADDR_W),
        .ENTRY_W (ADDR_W)
    ) u_decode (
        .entry    (mem_rd_data),
        .va       (cap_va),
        .is_write (cap_wr),
        .attr     (ent_attr),
        .paddr    (ent_paddr)
    );

    // Snapshot of request and configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va   <= '0;
            cap_wr   <= 1'b0;
            cap_en   <= 1'b0;
            cap_big  <= 1'b0;
            cap_code <= '0;
            cap_base <= '0;
        end else if (accept) begin
            cap_va   <= req_addr;
            cap_wr   <= req_write;
            cap_en   <= ctrl_word[EN_BIT];
            cap_big  <= ctrl_word[MODE_BIT];
            cap_code <= ctrl_word[CODE_LSB +: CODE_W];
            cap_base <= tbl_base;
        end
    end

    // Entry address register, loaded when the fetch starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        mem_addr_q <= '0;
        else if (fetch_go) mem_addr_q <= cap_base + byte_off;
    end

    assign mem_rd_addr = mem_addr_q;

    // Response registers, loaded from the selected result source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault    <= 1'b0;
            rsp_perm     <= PERM_NONE;
            rsp_page_64k <= 1'b0;
            rsp_paddr    <= '0;
        end else if (load_pass) begin
            rsp_fault    <= 1'b0;
            rsp_perm     <= PERM_RW;
            rsp_page_64k <= 1'b0;
            rsp_paddr    <= cap_va;
        end else if (load_rsvd) begin
            rsp_fault    <= 1'b1;
            rsp_perm     <= PERM_NONE;
            rsp_page_64k <= 1'b0;
            rsp_paddr    <= '0;
        end else if (load_entry) begin
            rsp_fault    <= ent_attr.fault;
            rsp_perm     <= ent_attr.perm;
            rsp_page_64k <= ent_attr.page_64k;
            rsp_paddr    <= ent_paddr;
        end
    end

endmodule

// File: rtl/iowalk_checker.sv
`timescale 1ns/1ps
// Protocol checker for the table walker, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module iowalk_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic              done,
    input logic              rsp_fault,
    input logic [1:0]        rsp_perm,
    input logic              rsp_page_64k
);
    // R2: an accepted request makes the walker busy on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: done is a single-cycle pulse.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: idle never overlaps a pending result or a read.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!done && !mem_rd_req));

    // R11: read request and address stay put until acknowledged.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R11: an acknowledged read is answered on the next cycle.
    a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack) |=> (done && !mem_rd_req));

    // R8: the reserved permission code never appears.
    a_r8_perm_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_perm != 2'b10));

    // R10: a successful answer always carries a permission; faults carry no page flag.
    a_r10_fault_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_fault ? !rsp_page_64k : (rsp_perm != 2'b00)));

endmodule

bind iova_table_walker iowalk_checker #(.ADDR_W(ADDR_W)) u_iowalk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .done         (done),
    .rsp_fault    (rsp_fault),
    .rsp_perm     (rsp_perm),
    .rsp_page_64k (rsp_page_64k)
);

// File: tb/iova_table_walker_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the walk, compared on every clock.
module iova_table_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ctrl_word;
    logic [63:0] tbl_base;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        req_write;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_ack;
    logic [63:0] mem_rd_data;
    logic        done;
    logic        rsp_fault;
    logic [1:0]  rsp_perm;
    logic        rsp_page_64k;
    logic [63:0] rsp_paddr;

    int compared   = 0;
    int mismatched = 0;

    logic [63:0] mem [logic [63:0]];

    iova_table_walker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_word    (ctrl_word),
        .tbl_base     (tbl_base),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ack   (mem_rd_ack),
        .mem_rd_data  (mem_rd_data),
        .done         (done),
        .rsp_fault    (rsp_fault),
        .rsp_perm     (rsp_perm),
        .rsp_page_64k (rsp_page_64k),
        .rsp_paddr    (rsp_paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit big, input int code);
        logic [31:0] c;
        c        = '0;
        c[0]     = en;
        c[2]     = big;
        c[18:16] = code[2:0];
        return c;
    endfunction

    // Entry address predicted from the requirements (R4, R5).
    function automatic logic [63:0] entry_addr(input logic [31:0] c, input logic [63:0] b, input logic [63:0] va);
        int n;
        logic [63:0] win;
        n   = int'(c[18:16]);
        win = (64'd1 << (10 + n)) - 64'd1;
        if (c[2]) return b + (((va >> 16) & win) << 3);
        else      return b + (((va >> 13) & win) << 3);
    endfunction

    task automatic put(input logic [63:0] va, input logic [63:0] ent);
        mem[entry_addr(ctrl_word, tbl_base, va)] = ent;
    endtask

    task automatic run_txn(input logic [63:0] va, input bit wr, input int ack_dly,
                           input bit hold_valid, input bit scramble, input string rq);
        logic [31:0] c;
        logic [63:0] b;
        logic [63:0] raddr;
        logic [63:0] ent;
        logic [63:0] e_pa;
        logic [1:0]  e_perm;
        bit          e_fault;
        bit          e_pg;
        bit          e_read;
        int          phase;
        int          waited;
        int          cyc;
        c = ctrl_word;
        b = tbl_base;
        raddr = 64'd0;
        ent = 64'd0;
        e_read = 1'b0;
        if (!c[0]) begin
            e_pa = va; e_perm = 2'b11; e_fault = 1'b0; e_pg = 1'b0;
        end else if (c[2] && int'(c[18:16]) > 5) begin
            e_pa = 64'd0; e_perm = 2'b00; e_fault = 1'b1; e_pg = 1'b0;
        end else begin
            e_read = 1'b1;
            raddr  = entry_addr(c, b, va);
            ent    = mem.exists(raddr) ? mem[raddr] : 64'd0;
            e_perm = !ent[63] ? 2'b00 : (ent[1] ? 2'b11 : 2'b01);
            e_fault = !ent[63] || (wr && !ent[1]);
            if (e_fault) begin
                e_pa = 64'd0; e_pg = 1'b0;
            end else if (ent[61]) begin
                e_pa = (ent & 64'h1FF_FFFF_8000) | (va & 64'hFFFF); e_pg = 1'b1;
            end else begin
                e_pa = (ent & 64'h1FF_FFFF_E000) | (va & 64'h1FFF); e_pg = 1'b0;
            end
        end
        @(negedge clk);
        chk(rq, "ready before request", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1;
        req_addr  = va;
        req_write = wr;
        @(posedge clk);
        phase = 1; waited = 0; cyc = 0;
        while (phase != 0 && cyc < 64) begin
            @(negedge clk);
            cyc++;
            mem_rd_ack = 1'b0;
            if (cyc == 1 && !hold_valid) req_valid = 1'b0;
            if (cyc == 1 && scramble) begin
                ctrl_word = ctrl_word ^ 32'h0005_0001;
                tbl_base  = tbl_base ^ 64'h0000_0000_0010_0000;
            end
            case (phase)
                1: begin
                    chk(rq, "ready while deciding", {63'd0, req_ready}, 64'd0);
                    chk(rq, "done while deciding", {63'd0, done}, 64'd0);
                    chk(rq, "read while deciding", {63'd0, mem_rd_req}, 64'd0);
                    phase = e_read ? 2 : 3;
                end
                2: begin
                    chk(rq, "read request (R11)", {63'd0, mem_rd_req}, 64'd1);
                    chk(rq, "entry address", mem_rd_addr, raddr);
                    chk(rq, "done while fetching", {63'd0, done}, 64'd0);
                    chk(rq, "ready while fetching", {63'd0, req_ready}, 64'd0);
                    if (waited == ack_dly) begin
                        mem_rd_ack  = 1'b1;
                        mem_rd_data = ent;
                        phase = 3;
                    end else begin
                        waited++;
                    end
                end
                3: begin
                    chk(rq, "done pulse", {63'd0, done}, 64'd1);
                    chk(rq, "read after result", {63'd0, mem_rd_req}, 64'd0);
                    chk(rq, "ready at result", {63'd0, req_ready}, 64'd0);
                    chk(rq, "fault", {63'd0, rsp_fault}, {63'd0, e_fault});
                    chk(rq, "perm", {62'd0, rsp_perm}, {62'd0, e_perm});
                    chk(rq, "page size", {63'd0, rsp_page_64k}, {63'd0, e_pg});
                    chk(rq, "paddr", rsp_paddr, e_pa);
                    req_valid = 1'b0;
                    phase = 4;
                end
                default: begin
                    chk(rq, "done after pulse (R2)", {63'd0, done}, 64'd0);
                    chk(rq, "ready after pulse (R2)", {63'd0, req_ready}, 64'd1);
                    chk(rq, "read after pulse", {63'd0, mem_rd_req}, 64'd0);
                    phase = 0;
                end
            endcase
        end
        if (phase != 0) chk(rq, "walk finished in time", 64'd0, 64'd1);
        if (scramble) begin
            ctrl_word = c;
            tbl_base  = b;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ctrl_word = '0;
        tbl_base = 64'h0000_0001_2340_0000;
        req_valid = 1'b0;
        req_addr = '0;
        req_write = 1'b0;
        mem_rd_ack = 1'b0;
        mem_rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ready", {63'd0, req_ready}, 64'd1);
        chk("R1", "done", {63'd0, done}, 64'd0);
        chk("R1", "read", {63'd0, mem_rd_req}, 64'd0);
        chk("R1", "fault", {63'd0, rsp_fault}, 64'd0);
        chk("R1", "perm", {62'd0, rsp_perm}, 64'd0);
        chk("R1", "page", {63'd0, rsp_page_64k}, 64'd0);

        // R3: pass-through, reads and writes
        ctrl_word = mk(0, 0, 3);
        run_txn(64'hDEAD_BEEF_1234_5678, 1'b0, 0, 1'b0, 1'b0, "R3");
        run_txn(64'h0000_0000_0000_1FFF, 1'b1, 0, 1'b0, 1'b0, "R3");

        // R4, R8, R9: small table mode, read-write small page
        ctrl_word = mk(1, 0, 0);
        put(64'h0000_0000_0055_A123, 64'h8000_0000_0ABC_D002);
        run_txn(64'h0000_0000_0055_A123, 1'b0, 0, 1'b0, 1'b0, "R4");
        run_txn(64'h0000_0000_0055_A123, 1'b1, 1, 1'b0, 1'b0, "R8");
        // R4: bits above the window do not change the entry
        run_txn(64'h0000_0100_00D5_A123, 1'b0, 0, 1'b0, 1'b0, "R4");

        // R4, R8: largest small-mode window, read-only entry
        ctrl_word = mk(1, 0, 7);
        put(64'h0000_0000_3FFF_E777, 64'h8000_0001_2345_6000);
        run_txn(64'h0000_0000_3FFF_E777, 1'b0, 2, 1'b0, 1'b0, "R8");
        // R10: write against read-only
        run_txn(64'h0000_0000_3FFF_E777, 1'b1, 0, 1'b0, 1'b0, "R10");

        // R9: large page in a small-mode table
        ctrl_word = mk(1, 0, 3);
        put(64'h0000_0000_02AB_CDEF, 64'hA000_0000_7777_8003);
        run_txn(64'h0000_0000_02AB_CDEF, 1'b1, 0, 1'b0, 1'b0, "R9");

        // R5: large table mode, smallest and largest legal codes
        ctrl_word = mk(1, 1, 0);
        put(64'h0000_0000_0123_4567, 64'hA000_0001_FFFF_F002);
        run_txn(64'h0000_0000_0123_4567, 1'b0, 0, 1'b0, 1'b0, "R5");
        ctrl_word = mk(1, 1, 5);
        put(64'h0000_0000_7FFF_0123, 64'h8000_0000_0004_2002);
        run_txn(64'h0000_0000_7FFF_0123, 1'b0, 0, 1'b0, 1'b0, "R5");

        // R6: reserved codes in large table mode
        ctrl_word = mk(1, 1, 6);
        run_txn(64'h0000_0000_0123_4567, 1'b0, 0, 1'b0, 1'b0, "R6");
        ctrl_word = mk(1, 1, 7);
        run_txn(64'h0000_0000_0123_4567, 1'b1, 0, 1'b0, 1'b0, "R6");

        // R7: invalid entry, and an unmapped slot reading as zero
        ctrl_word = mk(1, 0, 2);
        put(64'h0000_0000_0111_2000, 64'h2000_0000_0ABC_D002);
        run_txn(64'h0000_0000_0111_2000, 1'b0, 0, 1'b0, 1'b0, "R7");
        run_txn(64'h0000_0000_01F0_0000, 1'b0, 0, 1'b0, 1'b0, "R7");

        // R11: long acknowledge delay
        ctrl_word = mk(1, 0, 0);
        run_txn(64'h0000_0000_0055_A123, 1'b0, 6, 1'b0, 1'b0, "R11");

        // R12: configuration changed during the walk
        run_txn(64'h0000_0000_0055_A123, 1'b0, 3, 1'b0, 1'b1, "R12");
        ctrl_word = mk(0, 0, 0);
        run_txn(64'h0000_0000_0055_A123, 1'b0, 0, 1'b0, 1'b1, "R12");

        // R2: request held valid while busy
        ctrl_word = mk(1, 0, 0);
        run_txn(64'h0000_0000_0055_A123, 1'b0, 2, 1'b1, 1'b0, "R2");
        @(negedge clk);
        chk("R2", "no second accept", {63'd0, req_ready}, 64'd1);
        chk("R2", "no stray read", {63'd0, mem_rd_req}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule